// File: doc/BRIEF.md
# Display Update Phase Sequencer

This block sits on the controller side of an electrophoretic panel driver. It watches the stream of command and data bytes coming from the host. It keeps an 8-bit update-control mask, and when the host issues the start command it steps through up to seven power and drive phases in a fixed order. While the sequence runs, an active-high busy line stays asserted. Each phase is carried out by a stub unit that is started by a one-cycle pulse and reports completion after a latency set by parameters, so the sequencer's ordering, skipping and timing can be observed directly.

The mask byte is loaded by the mask command (byte 0x22) followed by one data byte. The start command (byte 0x20) takes a snapshot of the mask and runs the enabled phases from the highest bit down. Oscillator and analog-rail state persist between activations, so a mask that only loads temperature, loads the waveform table and drives is valid after an earlier activation has powered up. If drive is requested while the rails are down, the drive phase is skipped, an error flag is raised and the remaining phases still run.

Top module: `upd_seq_ctrl`

## Requirements
- R1: After reset, busy, phase_act, drive_mode2, clk_on, ana_on and drive_err are all 0, and the stored mask is 0x00.
- R2: A command byte 0x22 (in_is_data=0) followed by the next valid byte as data (in_is_data=1) loads that byte as the mask. A data byte that does not directly follow 0x22 is ignored, and so is a data byte that comes after some other command.
- R3: A command byte 0x20 accepted while idle raises busy in the next cycle. Busy then stays high for exactly 7 + the sum of the latencies of the phases that run, and then falls.
- R4: Phases are slots 0..6, mapped to mask bits 7,6,5,4,2,1,0 (oscillator on, rails on, temperature load, table load, drive, rails off, oscillator off). They run in ascending slot order (descending bit order). Bit 3 is not a phase. A disabled slot takes one cycle and never shows on phase_act.
- R5: phase_act is one-hot while a phase runs, with bit i standing for slot i, and slot i stays active for LAT_BASE + LAT_STEP*i cycles.
- R6: clk_on is set when the oscillator-on phase completes and cleared when the oscillator-off phase completes. ana_on behaves the same way for rails on and rails off. Both hold their values across activations.
- R7: With the oscillator and rails already on, mask 0x34 runs exactly temperature load, table load and drive, without error.
- R8: drive_mode2 is high exactly while the drive phase runs with mask bit 3 set. Mask 0x0C runs only the drive phase, with no table load.
- R9: If the drive bit is set while ana_on is 0 at the drive slot, drive_err is set, the drive phase is skipped (one cycle) and later phases still run. drive_err is cleared when the next activation is accepted.
- R10: A 0x20 command received while busy is ignored: the run is neither restarted nor lengthened.
- R11: A mask load received while busy does not change the running sequence, but it takes effect at the next activation.
- R12: Mask 0x83 performs a power-off: oscillator on, rails off, oscillator off, leaving clk_on=0 and ana_on=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_vld | input | 1 | Host byte valid this cycle |
| in_is_data | input | 1 | 1 = data byte, 0 = command byte |
| in_byte | input | 8 | Host byte |
| busy | output | 1 | High while a sequence runs |
| phase_act | output | 7 | One-hot running phase, bit i = slot i |
| drive_mode2 | output | 1 | Drive phase running in mode 2 |
| clk_on | output | 1 | Oscillator state |
| ana_on | output | 1 | Analog rail state |
| drive_err | output | 1 | Drive requested with rails off |

## Verification
Directed masks isolate single behaviours. 0xF4 from a cold start checks the full power-up order and timing. 0x34 and 0x0C check persistence and the mode-2 drive without a table load. 0x83 checks power-off, and a drive-only mask from cold checks the error-and-continue path. Bytes injected mid-run separate an ignored start from a mask update that is deferred to the next activation. Stray data bytes show that the two-byte mask load is enforced. Random masks applied back to back, with rail state carried between them, are checked against a bench model of the phase sequence, the busy length, the error flag and the final power state.

// File: rtl/upd_seq_pkg.sv
package upd_seq_pkg;
   localparam int NPH        = 7;
   localparam int SLOT_W     = 3;
   localparam int SLOT_CKON  = 0;
   localparam int SLOT_ANON  = 1;
   localparam int SLOT_DRIVE = 4;
   localparam int SLOT_ANOFF = 5;
   localparam int SLOT_CKOFF = 6;
   localparam int MODE_BIT   = 3;

   typedef enum logic [1:0] {ST_IDLE, ST_PICK, ST_RUN} seq_st_t;

   // mask bit owned by a phase slot: slots 0..3 -> bits 7..4, slots 4..6 -> bits 2..0
   function automatic logic [2:0] slot_bit(input logic [SLOT_W-1:0] s);
      if (s < 3'd4) return 3'd7 - s;
      else          return 3'd6 - s;
   endfunction
endpackage

// File: rtl/upd_cmd_dec.sv
module upd_cmd_dec #(
   parameter int          BW       = 8,
   parameter logic [BW-1:0] CMD_MASK = 8'h22,
   parameter logic [BW-1:0] CMD_GO   = 8'h20
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_vld,
   input  logic          in_is_data,
   input  logic [BW-1:0] in_byte,
   output logic          go,
   output logic          mask_wr,
   output logic [BW-1:0] mask_q
);
   logic expect_q;

   assign go      = in_vld && !in_is_data && (in_byte == CMD_GO);
   assign mask_wr = in_vld &&  in_is_data && expect_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         expect_q <= 1'b0;
         mask_q   <= '0;
      end else begin
         if (in_vld) expect_q <= !in_is_data && (in_byte == CMD_MASK);
         if (mask_wr) mask_q <= in_byte;
      end
   end

   p_wr_not_go_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mask_wr |-> !go);
   p_mask_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_wr |=> $stable(mask_q));
endmodule

// File: rtl/upd_phase_stub.sv
module upd_phase_stub #(
   parameter int LAT = 2,
   parameter int CW  = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic done
);
   logic [CW-1:0] cnt_q;

   if (LAT < 1) begin : g_bad_lat
      $error("phase latency must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (start)        cnt_q <= CW'(LAT);
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == CW'(1));

   p_no_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> cnt_q == '0);
endmodule

// File: rtl/upd_seq_fsm.sv
module upd_seq_fsm
   import upd_seq_pkg::*;
#(
   parameter int BW = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           go,
   input  logic [BW-1:0]  mask_in,
   input  logic [NPH-1:0] ph_done,
   output logic [NPH-1:0] ph_start,
   output logic [NPH-1:0] phase_act,
   output logic           busy,
   output logic           drive_mode2,
   output logic           clk_on,
   output logic           ana_on,
   output logic           drive_err
);
   seq_st_t           st_q;
   logic [SLOT_W-1:0] cur_q;
   logic [BW-1:0]     run_mask_q;
   logic              en, blocked, last;
   logic [NPH-1:0]    cur_oh;

   always_comb begin
      cur_oh  = NPH'(1) << cur_q;
      en      = run_mask_q[slot_bit(cur_q)];
      blocked = (cur_q == SLOT_W'(SLOT_DRIVE)) && !ana_on;
      last    = (cur_q == SLOT_W'(NPH-1));
   end

   assign ph_start    = (st_q == ST_PICK && en && !blocked) ? cur_oh : '0;
   assign phase_act   = (st_q == ST_RUN) ? cur_oh : '0;
   assign drive_mode2 = phase_act[SLOT_DRIVE] && run_mask_q[MODE_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         cur_q      <= '0;
         run_mask_q <= '0;
         busy       <= 1'b0;
         clk_on     <= 1'b0;
         ana_on     <= 1'b0;
         drive_err  <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (go) begin
               run_mask_q <= mask_in;
               cur_q      <= '0;
               busy       <= 1'b1;
               drive_err  <= 1'b0;
               st_q       <= ST_PICK;
            end
            ST_PICK: begin
               if (en && !blocked) begin
                  st_q <= ST_RUN;
               end else begin
                  if (en) drive_err <= 1'b1;
                  if (last) begin
                     busy <= 1'b0;
                     st_q <= ST_IDLE;
                  end else begin
                     cur_q <= cur_q + 1'b1;
                  end
               end
            end
            ST_RUN: if (|(ph_done & cur_oh)) begin
               case (cur_q)
                  SLOT_W'(SLOT_CKON):  clk_on <= 1'b1;
                  SLOT_W'(SLOT_ANON):  ana_on <= 1'b1;
                  SLOT_W'(SLOT_ANOFF): ana_on <= 1'b0;
                  SLOT_W'(SLOT_CKOFF): clk_on <= 1'b0;
                  default: ;
               endcase
               if (last) begin
                  busy <= 1'b0;
                  st_q <= ST_IDLE;
               end else begin
                  cur_q <= cur_q + 1'b1;
                  st_q  <= ST_PICK;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   p_act_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(phase_act));
   p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> phase_act == '0);
   p_drive_rails_r9: assert property (@(posedge clk) disable iff (!rst_n)
      phase_act[SLOT_DRIVE] |-> ana_on);
   p_err_in_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drive_err) |-> $past(busy));
   p_go_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && go) |=> $stable(run_mask_q));
   p_mode2_in_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
      drive_mode2 |-> phase_act[SLOT_DRIVE]);
   p_start_when_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_start != '0) |-> busy);
endmodule

// File: rtl/upd_seq_ctrl.sv
module upd_seq_ctrl
   import upd_seq_pkg::*;
#(
   parameter int              BW       = 8,
   parameter logic [BW-1:0]   CMD_MASK = 8'h22,
   parameter logic [BW-1:0]   CMD_GO   = 8'h20,
   parameter int              LAT_BASE = 2,
   parameter int              LAT_STEP = 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           in_vld,
   input  logic           in_is_data,
   input  logic [BW-1:0]  in_byte,
   output logic           busy,
   output logic [NPH-1:0] phase_act,
   output logic           drive_mode2,
   output logic           clk_on,
   output logic           ana_on,
   output logic           drive_err
);
   localparam int LAT_MAX = LAT_BASE + LAT_STEP * (NPH - 1);
   localparam int CW      = $clog2(LAT_MAX + 1);

   if (BW != 8) begin : g_bad_bw
      $error("mask byte width must be 8");
   end
   if (LAT_BASE < 1 || LAT_STEP < 0) begin : g_bad_lat
      $error("phase latency parameters out of range");
   end

   logic           go, mask_wr;
   logic [BW-1:0]  mask_q;
   logic [NPH-1:0] ph_start, ph_done;

   upd_cmd_dec #(.BW(BW), .CMD_MASK(CMD_MASK), .CMD_GO(CMD_GO)) u_dec (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_is_data(in_is_data),
      .in_byte(in_byte), .go(go), .mask_wr(mask_wr), .mask_q(mask_q));

   for (genvar i = 0; i < NPH; i++) begin : g_stub
      upd_phase_stub #(.LAT(LAT_BASE + LAT_STEP * i), .CW(CW)) u_stub (
         .clk(clk), .rst_n(rst_n), .start(ph_start[i]), .done(ph_done[i]));
   end

   upd_seq_fsm #(.BW(BW)) u_fsm (
      .clk(clk), .rst_n(rst_n), .go(go), .mask_in(mask_q),
      .ph_done(ph_done), .ph_start(ph_start), .phase_act(phase_act),
      .busy(busy), .drive_mode2(drive_mode2), .clk_on(clk_on),
      .ana_on(ana_on), .drive_err(drive_err));

   p_busy_needs_go_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(go));
endmodule

// File: tb/sim_upd_seq_ctrl.sv
module sim_upd_seq_ctrl;
   localparam int LB = 2, LS = 1;
   logic clk = 0, rst_n = 0;
   logic in_vld = 0, in_is_data = 0;
   logic [7:0] in_byte = 0;
   logic busy, drive_mode2, clk_on, ana_on, drive_err;
   logic [6:0] phase_act;
   int total = 0, bad = 0;
   bit finished = 0;

   // model state
   bit m_clk = 0, m_ana = 0;
   // measured run results
   int r_len, r_drv_len;
   logic [31:0] r_seq;
   bit r_mode2_seen;

   always #2 clk = ~clk;

   upd_seq_ctrl #(.LAT_BASE(LB), .LAT_STEP(LS)) u0 (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_is_data(in_is_data),
      .in_byte(in_byte), .busy(busy), .phase_act(phase_act),
      .drive_mode2(drive_mode2), .clk_on(clk_on), .ana_on(ana_on),
      .drive_err(drive_err));

   function automatic int sbit(int s);
      return (s < 4) ? 7 - s : 6 - s;
   endfunction

   task automatic chk(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic put(bit dc, logic [7:0] b);
      in_vld = 1; in_is_data = dc; in_byte = b;
      @(negedge clk);
      in_vld = 0;
   endtask

   // inj: 0 none, 1 start cmd mid-run, 2 mask load of inj_b mid-run
   task automatic run(int inj, logic [7:0] inj_b);
      logic [6:0] prev = 0;
      r_len = 0; r_drv_len = 0; r_seq = 0; r_mode2_seen = 0;
      put(0, 8'h20);
      while (busy && r_len < 5000) begin
         if (phase_act != prev && phase_act != 0)
            for (int i = 0; i < 7; i++)
               if (phase_act[i]) r_seq = {r_seq[27:0], 4'(i + 1)};
         if (phase_act[4]) r_drv_len++;
         if (drive_mode2) r_mode2_seen = 1;
         prev = phase_act;
         in_vld = 0;
         if (inj == 1 && r_len == 3) begin in_vld = 1; in_is_data = 0; in_byte = 8'h20; end
         if (inj == 2 && r_len == 3) begin in_vld = 1; in_is_data = 0; in_byte = 8'h22; end
         if (inj == 2 && r_len == 4) begin in_vld = 1; in_is_data = 1; in_byte = inj_b; end
         r_len++;
         @(negedge clk);
      end
      in_vld = 0;
   endtask

   // expected run from the requirements; updates model power state
   task automatic model(logic [7:0] m, output int len, output logic [31:0] seq,
                        output bit err);
      len = 0; seq = 0; err = 0;
      for (int s = 0; s < 7; s++) begin
         if (m[sbit(s)] && !(s == 4 && !m_ana)) begin
            len += 1 + LB + LS * s;
            seq = {seq[27:0], 4'(s + 1)};
            if (s == 0) m_clk = 1;
            if (s == 1) m_ana = 1;
            if (s == 5) m_ana = 0;
            if (s == 6) m_clk = 0;
         end else begin
            if (m[sbit(s)]) err = 1;
            len += 1;
         end
      end
   endtask

   task automatic full(string req, logic [7:0] m, int inj, logic [7:0] ib);
      int el; logic [31:0] es; bit ee;
      model(m, el, es, ee);
      run(inj, ib);
      chk({req, " busy length"}, r_len, el);
      chk({req, " phase order"}, r_seq, es);
      chk({req, " drive_err"}, drive_err, ee);
      chk({req, " clk_on"}, clk_on, m_clk);
      chk({req, " ana_on"}, ana_on, m_ana);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 busy", busy, 0); chk("R1 phase_act", phase_act, 0);
      chk("R1 clk_on", clk_on, 0); chk("R1 ana_on", ana_on, 0);
      chk("R1 drive_err", drive_err, 0); chk("R1 mode2", drive_mode2, 0);
      rst_n = 1; @(negedge clk);
      // R1 mask resets to 0: 7 idle slots
      full("R1 zero mask", 8'h00, 0, 0);
      // R2 stray data ignored; mask load then other command; then real load
      put(1, 8'hF4); full("R2 stray data", 8'h00, 0, 0);
      put(0, 8'h22); put(0, 8'h11); put(1, 8'hF4);
      full("R2 data after other cmd", 8'h00, 0, 0);
      // R4 R5 R3 full power-up + drive, mode 1
      put(0, 8'h22); put(1, 8'hF4);
      full("R4 power-up order", 8'hF4, 0, 0);
      chk("R5 drive phase length", r_drv_len, LB + 4 * LS);
      chk("R8 mode2 low without bit3", r_mode2_seen, 0);
      // R7 persistence, 0x34
      put(0, 8'h22); put(1, 8'h34);
      full("R7 temp+table+drive", 8'h34, 0, 0);
      // R8 mode 2 drive without table load
      put(0, 8'h22); put(1, 8'h0C);
      full("R8 mode2 drive", 8'h0C, 0, 0);
      chk("R8 mode2 seen", r_mode2_seen, 1);
      // R10 start while busy ignored
      full("R10 start during run", 8'h0C, 1, 0);
      // R11 mask load during run: current run unchanged
      full("R11 current run", 8'h0C, 2, 8'h83);
      // R12 new mask 0x83 applies at next activation: power off
      full("R12 power-off", 8'h83, 0, 0);
      chk("R6 clk off after power-off", clk_on, 0);
      // R9 drive with rails down: error, later phases still run
      put(0, 8'h22); put(1, 8'h05);
      full("R9 drive without rails", 8'h05, 0, 0);
      chk("R9 error set", drive_err, 1);
      chk("R6 clk state kept", clk_on, 0);
      put(0, 8'h22); put(1, 8'hC0);
      full("R9 error cleared", 8'hC0, 0, 0);
      chk("R6 rails kept on", ana_on, 1);
      // random masks, state carried across runs
      for (int k = 0; k < 60; k++) begin
         logic [7:0] m = 8'($urandom);
         put(0, 8'h22); put(1, m);
         full("R4 random", m, 0, 0);
      end
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule